// File: doc/BRIEF.md
# Scatter-Gather Trace Address Walker

This block supplies physical write addresses to a trace byte-stream writer whose buffer is scattered across 4 KB pages in memory. Software fills one or more 4 KB tables with 32-bit entries. A programmed base points at the first table. Each entry is one of four kinds: a data page, a link to another table, the final data page of the chain, or a reserved code. The walker reads entries on a simple request/response port. It hands out sequential 8-byte beat addresses inside the current data page, and it fetches the following entry while that page is still being filled.

The page chain is treated as a ring. When the final data page is full, the walker pulses a wrap indication and starts over at entry 0 of the base table. A reserved entry raises a sticky error and stops the address stream until a new start pulse arrives. A start pulse always re-arms the walker from the base currently presented.

Top module: `sg_trace_walker`

## Requirements
- R1: After reset, and until the first start pulse, `wr_ready`, `mem_req_valid`, `err` and `wrap` are all low, and no entry request is issued.
- R2: A start pulse captures `table_base` with its low 12 bits forced to zero. The first entry request goes to that aligned address. `wr_ready` is low in the cycle after the pulse and stays low until a data-page entry has been decoded.
- R3: An entry whose bits [1:0] are 2'b10 is a normal data page. Its page address is entry bits [31:4] placed at address bits [39:12], with zeros below. Accepted beats receive page+0, page+8, and so on up to page+4088. The next entry is requested at the previous entry address plus 4.
- R4: An entry of type 2'b11 is a link. The next request goes to entry bits [31:4] shifted to address bits [39:12], and the link produces no write address of its own.
- R5: An entry of type 2'b01 is the final data page. After the last beat of that page is accepted, `wrap` is high for exactly one cycle, and the next page handed out comes from entry 0 of the captured base table.
- R6: An entry of type 2'b00 sets `err`, which is sticky. From the next cycle onward `wr_ready` is low, even in the middle of a page, and no further requests are made. A start pulse clears `err` and re-arms the walker.
- R7: If responses return within a few cycles and `wr_valid` is held high, `wr_ready` never drops at a page boundary. The next page's entry has already been fetched.
- R8: Entry bits [3:2] have no effect on the page address.
- R9: While `wr_valid` is low, `wr_addr` holds its value and the in-page offset does not advance.
- R10: Once `mem_req_valid` is asserted, it stays high with a stable `mem_req_addr` until `mem_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse: capture base and (re)start the walk |
| table_base | input | 40 | Physical address of the first table (low 12 bits ignored) |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the entry read request |
| mem_req_addr | output | 40 | Address of the 32-bit entry to read |
| mem_rsp_valid | input | 1 | Entry read data valid |
| mem_rsp_data | input | 32 | Entry read data |
| wr_valid | input | 1 | Writer offers one 8-byte beat |
| wr_ready | output | 1 | An address is available; beat accepted when both are high |
| wr_addr | output | 40 | Physical address for the current beat |
| wrap | output | 1 | One-cycle pulse after the final page of the chain is full |
| err | output | 1 | Sticky flag: a reserved entry was read |

## Verification
The hardest situation to reach from the ports is a full turn of the ring. It takes more than 1500 accepted beats across a link into a second table before the final page completes, the wrap pulse fires and the walk returns to the base table. The bench keeps `wr_valid` high and answers entry reads from a modelled memory holding two chained tables. Every beat address is compared against a page list that the bench builds from the tables it wrote. A second, single-page ring confirms the wrap without a link. The reserved-entry case is placed directly after a valid page, so the error lands while that page is only partly filled.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int unsigned ENT_W     = 32;
  localparam int unsigned ET_W      = 2;
  localparam int unsigned PN_LSB    = 4;
  localparam int unsigned PG_SHIFT  = 12;
  localparam int unsigned PN_W      = ENT_W - PN_LSB;
  localparam int unsigned PA_W      = PN_W + PG_SHIFT;
  localparam int unsigned PG_BYTES  = 1 << PG_SHIFT;
  localparam int unsigned ENT_BYTES = ENT_W / 8;

  typedef enum logic [ET_W-1:0] {
    KIND_RSVD = 2'b00,
    KIND_LAST = 2'b01,
    KIND_PAGE = 2'b10,
    KIND_LINK = 2'b11
  } sg_kind_e;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2
  } fetch_st_e;

  function automatic logic [PN_W-1:0] entry_page(input logic [ENT_W-1:0] e);
    return e[ENT_W-1:PN_LSB];
  endfunction
endpackage

// File: rtl/sgw_entry_fetch.sv
module sgw_entry_fetch
  import sgw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [PA_W-1:0]     base_i,
  output logic                req_valid_o,
  input  logic                req_ready_i,
  output logic [PA_W-1:0]     req_addr_o,
  input  logic                rsp_valid_i,
  input  logic [ENT_W-1:0]    rsp_data_i,
  input  logic                take_i,
  output logic                slot_valid_o,
  output logic [PN_W-1:0]     slot_page_o,
  output logic                slot_last_o,
  output logic                err_o
);
  fetch_st_e         st_q, st_d;
  logic [PA_W-1:0]   ptr_q, ptr_d;
  logic [PN_W-1:0]   base_q, base_d;
  logic              slot_v_q, slot_v_d;
  logic [PN_W-1:0]   slot_pn_q, slot_pn_d;
  logic              slot_l_q, slot_l_d;
  logic              err_q, err_d;
  logic              armed_q, armed_d;
  logic              drop_q, drop_d;

  sg_kind_e          kind;
  logic [PN_W-1:0]   ent_pn;
  logic              sbz_unused;

  assign kind       = sg_kind_e'(rsp_data_i[ET_W-1:0]);
  assign ent_pn     = entry_page(rsp_data_i);
  assign sbz_unused = ^{rsp_data_i[PN_LSB-1:ET_W], base_i[PG_SHIFT-1:0]};

  always_comb begin
    st_d      = st_q;
    ptr_d     = ptr_q;
    base_d    = base_q;
    slot_v_d  = slot_v_q;
    slot_pn_d = slot_pn_q;
    slot_l_d  = slot_l_q;
    err_d     = err_q;
    armed_d   = armed_q;
    drop_d    = drop_q;

    if (take_i) slot_v_d = 1'b0;

    unique case (st_q)
      FS_IDLE: begin
        if (armed_q && !err_q && !slot_v_q) st_d = FS_REQ;
      end
      FS_REQ: begin
        if (req_ready_i) st_d = FS_WAIT;
      end
      FS_WAIT: begin
        if (rsp_valid_i) begin
          st_d = FS_IDLE;
          if (drop_q) begin
            drop_d = 1'b0;
          end else begin
            unique case (kind)
              KIND_PAGE: begin
                slot_v_d  = 1'b1;
                slot_pn_d = ent_pn;
                slot_l_d  = 1'b0;
                ptr_d     = ptr_q + PA_W'(ENT_BYTES);
              end
              KIND_LAST: begin
                slot_v_d  = 1'b1;
                slot_pn_d = ent_pn;
                slot_l_d  = 1'b1;
                ptr_d     = {base_q, {PG_SHIFT{1'b0}}};
              end
              KIND_LINK: begin
                ptr_d = {ent_pn, {PG_SHIFT{1'b0}}};
              end
              default: begin
                err_d = 1'b1;
              end
            endcase
          end
        end
      end
      default: st_d = FS_IDLE;
    endcase

    if (start_i) begin
      base_d   = base_i[PA_W-1:PG_SHIFT];
      ptr_d    = {base_i[PA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
      slot_v_d = 1'b0;
      slot_l_d = 1'b0;
      err_d    = 1'b0;
      armed_d  = 1'b1;
      if ((st_q == FS_REQ && req_ready_i) || (st_q == FS_WAIT && !rsp_valid_i)) begin
        st_d   = FS_WAIT;
        drop_d = 1'b1;
      end else begin
        st_d   = FS_IDLE;
        drop_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= FS_IDLE;
      ptr_q     <= '0;
      base_q    <= '0;
      slot_v_q  <= 1'b0;
      slot_pn_q <= '0;
      slot_l_q  <= 1'b0;
      err_q     <= 1'b0;
      armed_q   <= 1'b0;
      drop_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      ptr_q     <= ptr_d;
      base_q    <= base_d;
      slot_v_q  <= slot_v_d;
      slot_pn_q <= slot_pn_d;
      slot_l_q  <= slot_l_d;
      err_q     <= err_d;
      armed_q   <= armed_d;
      drop_q    <= drop_d;
    end
  end

  assign req_valid_o  = (st_q == FS_REQ);
  assign req_addr_o   = ptr_q;
  assign slot_valid_o = slot_v_q;
  assign slot_page_o  = slot_pn_q;
  assign slot_last_o  = slot_l_q;
  assign err_o        = err_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i && !start_i |=> req_valid_o && $stable(req_addr_o)); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_o && !start_i |=> err_o); // R6
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !req_valid_o); // R6
  AST_REQ_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> req_addr_o[1:0] == 2'b00); // R3
endmodule

// File: rtl/sgw_page_gen.sv
module sgw_page_gen
  import sgw_pkg::*;
#(
  parameter int unsigned BEAT_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              err_i,
  input  logic              slot_valid_i,
  input  logic [PN_W-1:0]   slot_page_i,
  input  logic              slot_last_i,
  output logic              take_o,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  output logic [PA_W-1:0]   wr_addr_o,
  output logic              wrap_o
);
  localparam logic [PG_SHIFT-1:0] STEP     = PG_SHIFT'(BEAT_BYTES);
  localparam logic [PG_SHIFT-1:0] LAST_OFF = PG_SHIFT'(PG_BYTES - BEAT_BYTES);

  logic                cur_v_q, cur_v_d;
  logic [PN_W-1:0]     cur_pn_q, cur_pn_d;
  logic                cur_l_q, cur_l_d;
  logic [PG_SHIFT-1:0] off_q, off_d;
  logic                wrap_q, wrap_d;
  logic                beat, page_end;

  assign wr_ready_o = cur_v_q && !err_i;
  assign beat       = wr_valid_i && wr_ready_o;
  assign page_end   = beat && (off_q == LAST_OFF);
  assign take_o     = slot_valid_i && !start_i && (!cur_v_q || page_end);

  always_comb begin
    cur_v_d  = cur_v_q;
    cur_pn_d = cur_pn_q;
    cur_l_d  = cur_l_q;
    off_d    = off_q;
    wrap_d   = 1'b0;
    if (start_i) begin
      cur_v_d = 1'b0;
      cur_l_d = 1'b0;
      off_d   = '0;
    end else begin
      wrap_d = page_end && cur_l_q;
      if (take_o) begin
        cur_v_d  = 1'b1;
        cur_pn_d = slot_page_i;
        cur_l_d  = slot_last_i;
        off_d    = '0;
      end else if (page_end) begin
        cur_v_d = 1'b0;
        off_d   = '0;
      end else if (beat) begin
        off_d = off_q + STEP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_v_q  <= 1'b0;
      cur_pn_q <= '0;
      cur_l_q  <= 1'b0;
      off_q    <= '0;
      wrap_q   <= 1'b0;
    end else begin
      cur_v_q  <= cur_v_d;
      cur_pn_q <= cur_pn_d;
      cur_l_q  <= cur_l_d;
      off_q    <= off_d;
      wrap_q   <= wrap_d;
    end
  end

  assign wr_addr_o = {cur_pn_q, off_q};
  assign wrap_o    = wrap_q;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_i && wr_ready_o && (wr_addr_o[PG_SHIFT-1:0] != LAST_OFF) && !start_i
    |=> wr_addr_o == $past(wr_addr_o) + PA_W'(BEAT_BYTES)); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready_o && !wr_valid_i && !start_i |=> $stable(wr_addr_o)); // R9
  AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> !wrap_o); // R5
endmodule

// File: rtl/sg_trace_walker.sv
module sg_trace_walker
  import sgw_pkg::*;
#(
  parameter int unsigned BEAT_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PA_W-1:0]   table_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ENT_W-1:0]  mem_rsp_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [PA_W-1:0]   wr_addr,
  output logic              wrap,
  output logic              err
);
  logic            slot_valid, slot_last, take;
  logic [PN_W-1:0] slot_page;

  sgw_entry_fetch u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .base_i       (table_base),
    .req_valid_o  (mem_req_valid),
    .req_ready_i  (mem_req_ready),
    .req_addr_o   (mem_req_addr),
    .rsp_valid_i  (mem_rsp_valid),
    .rsp_data_i   (mem_rsp_data),
    .take_i       (take),
    .slot_valid_o (slot_valid),
    .slot_page_o  (slot_page),
    .slot_last_o  (slot_last),
    .err_o        (err)
  );

  sgw_page_gen #(.BEAT_BYTES(BEAT_BYTES)) u_page (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .err_i        (err),
    .slot_valid_i (slot_valid),
    .slot_page_i  (slot_page),
    .slot_last_i  (slot_last),
    .take_o       (take),
    .wr_valid_i   (wr_valid),
    .wr_ready_o   (wr_ready),
    .wr_addr_o    (wr_addr),
    .wrap_o       (wrap)
  );

  AST_START_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !wr_ready); // R2
  AST_ERR_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !wr_ready); // R6
endmodule

// File: tb/sg_trace_walker_bench.sv
module sg_trace_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [39:0] table_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [39:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [39:0] wr_addr;
  logic        wrap;
  logic        err;

  always #10 clk = ~clk;

  sg_trace_walker u_sg_trace_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .table_base(table_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wrap(wrap), .err(err)
  );

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] mem_tbl [logic [39:0]];
  int          lat = 3;
  int          hold_cnt = 0;
  int          n_req = 0;
  logic [39:0] first_req = '0;

  bit          sink_on = 1'b0;
  bit          pause = 1'b0;
  bit          seen_rdy = 1'b0;
  int          beats = 0;
  int          wraps = 0;
  int          stalls = 0;
  logic [39:0] first_beat = '0;
  logic [27:0] exp_pages [$];
  int          exp_idx = 0;
  logic [11:0] exp_off = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [39:0] a);
    if (mem_tbl.exists(a)) return mem_tbl[a];
    return 32'h0;
  endfunction

  function automatic logic [31:0] ent(input logic [27:0] pn, input logic [1:0] sbz,
                                      input logic [1:0] kind);
    return {pn, sbz, kind};
  endfunction

  // memory responder: one outstanding read, fixed latency
  initial begin
    bit          busy = 1'b0;
    int          cnt = 0;
    logic [39:0] pa = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (busy) begin
        if (cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd(pa);
          busy = 1'b0;
        end else cnt--;
      end
      mem_req_ready = (hold_cnt == 0);
      if (hold_cnt > 0) hold_cnt--;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        busy = 1'b1;
        cnt  = lat;
        pa   = mem_req_addr;
        if (n_req == 0) first_req = mem_req_addr;
        n_req++;
      end
    end
  end

  // beat sink and address checker
  initial begin
    forever begin
      @(negedge clk);
      wr_valid = sink_on && !pause;
      #1;
      if (wr_ready) seen_rdy = 1'b1;
      if (sink_on && seen_rdy && !wr_ready && !err) stalls++;
      if (wrap) wraps++;
      if (wr_valid && wr_ready) begin
        if (beats == 0) first_beat = wr_addr;
        chk(wr_addr == {exp_pages[exp_idx], exp_off}, "R3/R4/R5", "beat address",
            64'(wr_addr), 64'({exp_pages[exp_idx], exp_off}));
        beats++;
        exp_off = exp_off + 12'd8;
        if (exp_off == 12'd0) exp_idx = (exp_idx + 1) % exp_pages.size();
      end
    end
  end

  task automatic reset_model();
    sink_on = 1'b0;
    pause = 1'b0;
    @(negedge clk);
    beats = 0; wraps = 0; stalls = 0; seen_rdy = 1'b0;
    exp_idx = 0; exp_off = '0;
    exp_pages.delete();
    mem_tbl.delete();
  endtask

  task automatic do_start(input logic [39:0] b);
    @(negedge clk);
    table_base = b;
    start = 1'b1;
    n_req = 0;
    @(negedge clk);
    start = 1'b0;
    #2;
    chk(wr_ready == 1'b0, "R2", "wr_ready right after start", 64'(wr_ready), 64'd0);
  endtask

  task automatic wait_beats(input int n);
    while (beats < n) @(negedge clk);
  endtask

  task automatic t_reset();
    #2;
    chk(wr_ready == 1'b0, "R1", "wr_ready after reset", 64'(wr_ready), 64'd0);
    chk(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", 64'(mem_req_valid), 64'd0);
    chk(err == 1'b0 && wrap == 1'b0, "R1", "err/wrap after reset", 64'({err, wrap}), 64'd0);
    repeat (10) @(negedge clk);
    chk(n_req == 0, "R1", "requests before start", 64'(n_req), 64'd0);
  endtask

  // two chained tables: page A, link, page B, final page C
  task automatic t_ring();
    logic [39:0] base = 40'h00_1234_5000;
    logic [39:0] t2   = 40'h00_0abc_d000;
    logic [27:0] pa = 28'h00a0001, pb = 28'h0b00b02, pc = 28'h0c0c003;
    reset_model();
    mem_tbl[base]      = ent(pa, 2'b11, 2'b10);   // R8: nonzero bits [3:2]
    mem_tbl[base + 4]  = ent(t2[39:12], 2'b00, 2'b11);
    mem_tbl[t2]        = ent(pb, 2'b00, 2'b10);
    mem_tbl[t2 + 4]    = ent(pc, 2'b00, 2'b01);
    exp_pages.push_back(pa); exp_pages.push_back(pb); exp_pages.push_back(pc);
    lat = 3;
    do_start(base | 40'h123);
    sink_on = 1'b1;
    while (n_req == 0) @(negedge clk);
    chk(first_req == base, "R2", "first entry request address", 64'(first_req), 64'(base));
    wait_beats(1);
    chk(first_beat == {pa, 12'h000}, "R8", "first beat ignores bits 3:2",
        64'(first_beat), 64'({pa, 12'h000}));
    wait_beats(3 * 512 + 16);
    chk(wraps == 1, "R5", "wrap pulses after one ring turn", 64'(wraps), 64'd1);
    chk(stalls == 0, "R7", "ready gaps at page boundaries", 64'(stalls), 64'd0);
    chk(err == 1'b0, "R4", "no error while following link", 64'(err), 64'd0);
  endtask

  task automatic t_pause();
    logic [39:0] held;
    pause = 1'b1;
    @(negedge clk); #2;
    held = wr_addr;
    repeat (10) @(negedge clk);
    #2;
    chk(wr_addr == held, "R9", "address held while wr_valid low", 64'(wr_addr), 64'(held));
    chk(wr_ready == 1'b1, "R9", "ready kept while idle", 64'(wr_ready), 64'd1);
    pause = 1'b0;
    wait_beats(beats + 600);
    chk(wraps == 1, "R5", "no extra wrap mid ring", 64'(wraps), 64'd1);
  endtask

  // page D followed by a reserved entry
  task automatic t_reserved();
    logic [39:0] base = 40'h00_0777_7000;
    logic [27:0] pd = 28'h0d0d004;
    int b0;
    reset_model();
    mem_tbl[base]     = ent(pd, 2'b00, 2'b10);
    mem_tbl[base + 4] = 32'h0000_1230;
    exp_pages.push_back(pd);
    do_start(base);
    sink_on = 1'b1;
    repeat (40) @(negedge clk);
    #2;
    chk(err == 1'b1, "R6", "err after reserved entry", 64'(err), 64'd1);
    chk(wr_ready == 1'b0, "R6", "wr_ready dropped mid page", 64'(wr_ready), 64'd0);
    b0 = beats;
    repeat (10) @(negedge clk);
    #2;
    chk(beats == b0, "R6", "no beats accepted under error", 64'(beats), 64'(b0));
    chk(err == 1'b1 && mem_req_valid == 1'b0, "R6", "error sticky and fetch quiet",
        64'({err, mem_req_valid}), 64'h2);
    sink_on = 1'b0;
  endtask

  // single final page with held-off request port
  task automatic t_hold();
    logic [39:0] base = 40'h00_0555_5000;
    logic [27:0] pe = 28'h0e0e005;
    reset_model();
    mem_tbl[base] = ent(pe, 2'b00, 2'b01);
    exp_pages.push_back(pe);
    hold_cnt = 6;
    do_start(base);
    chk(err == 1'b0, "R6", "start clears error", 64'(err), 64'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #2;
      chk(mem_req_valid == 1'b1 && mem_req_addr == base, "R10", "request held until ready",
          64'(mem_req_addr), 64'(base));
    end
    sink_on = 1'b1;
    wait_beats(700);
    chk(wraps == 1, "R5", "single page ring wraps", 64'(wraps), 64'd1);
    sink_on = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    fork
      begin
        t_reset();
        t_ring();
        t_pause();
        t_reserved();
        t_hold();
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule